// File: doc/BRIEF.md
# Two-Level Page Table Walker

This unit turns a 32-bit virtual address into a physical address. It walks a two-level page table that sits in memory. A request carries the virtual address, the kind of access (fetch, load or store), the effective privilege, and two status flags. The first flag lets supervisor code touch user pages. The second lets loads read execute-only pages. A control input enables translation and gives the page number of the root table.

The walker reads table entries over a valid/ready memory port. It writes an entry back once when the accessed or dirty flag must be set. It then returns one result: either a physical address with read, write and execute permissions, or a fault.

Three interfaces use valid/ready: the request, the memory request and the result. A transfer takes place on a rising clock edge where both valid and ready are high. Once valid is raised, it stays high and its payload stays stable until the transfer. The walker handles one request at a time and accepts a new request only when idle. It holds the result until `res_ready` takes it. It never raises `mem_req_valid` while a read response is still owed. The memory must return exactly one response per read, in a later cycle than the read request, and returns no response for a write.

Top module: `pt_walker`

## Requirements
- R1: Privilege code 3 (machine) or `xlat_on`=0 bypasses the walk. The result is the virtual address zero-extended to 34 bits, with R, W and X all set, and no memory access takes place.
- R2: The first entry is read at root_ppn*4096 + vaddr[31:22]*4. A second-level entry is read at ppn*4096 + vaddr[21:12]*4. An entry has V at bit 0, R at bit 1, W at bit 2, X at bit 3, U at bit 4, A at bit 6, D at bit 7, and its PPN in bits 31:10.
- R3: An entry with V=0 faults. A valid entry with R=W=X=0 points to the next table at the first level, and faults at the last level.
- R4: A leaf with W=1 and R=0 faults.
- R5: Privilege codes are 0 for user and 1 for supervisor. A U=1 page faults for supervisor unless `req_sum` is set, and always faults for a fetch. A U=0 page faults for user.
- R6: A leaf at the first level whose PPN bits 9:0 are not zero faults.
- R7: Access codes are 0 for fetch, 1 for load and 2 for store. A load needs R, or X with `req_mxr`. A store needs W. A fetch needs X.
- R8: A successful walk writes the leaf entry back to its own address with A set, and with D also set for a store. The write happens only if the entry changes.
- R9: A first-level leaf gives the physical address {ppn[21:10], vaddr[21:0]}. A second-level leaf gives {ppn, vaddr[11:0]}.
- R10: The reported permissions are r = R | (X & mxr), x = X, and w = W & (store | D).
- R11: A read response with `mem_rsp_err` set ends the walk with a fault.
- R12: A result stays stable while it waits for `res_ready`. A faulting result carries address 0 and no permissions. A memory request stays stable while it waits for `mem_req_ready`.
- R13: After reset, `req_ready` is 1, and `res_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_on | input | 1 | Translation enable (0 = bare) |
| root_ppn | input | 22 | Page number of the root table |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Execute-only pages readable by loads |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = entry writeback, 0 = entry read |
| mem_req_addr | output | 34 | Byte address of the entry |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| mem_rsp_err | input | 1 | Read failed |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_paddr | output | 34 | Physical address |
| res_fault | output | 1 | Translation failed |
| res_r | output | 1 | Read permission |
| res_w | output | 1 | Write permission |
| res_x | output | 1 | Execute permission |

## Verification
The bench builds the walker with its default parameters: two levels, 10-bit indices, 12-bit offsets and 22-bit page numbers. It places the root table at page 1 and the second-level tables at pages 2 and 3, so a 16 KiB memory model holds every table. A pointer to any higher page lands in the model's error region, which brings the error-response fault within reach. With random entry flags, random first-level superpages, and random ready and response delays, every fault cause can occur. So can both writeback outcomes and held results.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned B_V = 0;
  localparam int unsigned B_R = 1;
  localparam int unsigned B_W = 2;
  localparam int unsigned B_X = 3;
  localparam int unsigned B_U = 4;
  localparam int unsigned B_A = 6;
  localparam int unsigned B_D = 7;
  localparam int unsigned PPN_LSB = 10;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WAIT, ST_WBACK, ST_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_idx_gen.sv
module ptw_idx_gen #(
  parameter int LEVELS = 2,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 22,
  parameter int PTE_LG = 2,
  parameter int LVL_W  = 1,
  parameter int VA_W   = LEVELS * IDX_W + OFF_W,
  parameter int PA_W   = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PPN_W-1:0] leaf_ppn,
  output logic [PA_W-1:0]  pte_addr,
  output logic [PA_W-1:0]  leaf_paddr,
  output logic [PPN_W-1:0] lvl_mask
);
  localparam int VPN_W = LEVELS * IDX_W;

  logic [IDX_W-1:0] idx_at  [LEVELS];
  logic [PPN_W-1:0] mask_at [LEVELS];

  // one index slice and one superpage mask per table level
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign idx_at[g]  = vaddr[OFF_W + g*IDX_W +: IDX_W];
    assign mask_at[g] = PPN_W'((64'd1 << (g*IDX_W)) - 64'd1);
  end

  logic [PPN_W-1:0] vpn_ext;
  assign vpn_ext  = PPN_W'(vaddr[VA_W-1:OFF_W]);
  assign lvl_mask = mask_at[lvl];

  assign pte_addr   = {base_ppn, {OFF_W{1'b0}}} +
                      PA_W'({idx_at[lvl], {PTE_LG{1'b0}}});
  assign leaf_paddr = {leaf_ppn | (vpn_ext & lvl_mask), vaddr[OFF_W-1:0]};

  initial begin
    assert (PPN_W >= VPN_W)
      else $error("page number narrower than virtual page number");
  end
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
#(
  parameter int PPN_W = 22,
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [PPN_W-1:0] mis_mask,
  input  logic [1:0]       acc,
  input  logic [1:0]       priv,
  input  logic             sum,
  input  logic             mxr,
  output logic             is_ptr,
  output logic             bad,
  output logic             pr,
  output logic             pw,
  output logic             px,
  output logic             wb_need,
  output logic [PTE_W-1:0] wb_data
);
  logic v, r, w, x, u, d;
  logic [PPN_W-1:0] ppn;
  logic rsv_bad, priv_bad, mis_bad, acc_bad;

  always_comb begin
    v   = pte[B_V];
    r   = pte[B_R];
    w   = pte[B_W];
    x   = pte[B_X];
    u   = pte[B_U];
    d   = pte[B_D];
    ppn = pte[PTE_W-1:PPN_LSB];

    is_ptr   = v && !r && !w && !x;
    rsv_bad  = w && !r;
    priv_bad = (u && priv != PRIV_U && (!sum || acc == ACC_FETCH)) ||
               (!u && priv != PRIV_S);
    mis_bad  = |(ppn & mis_mask);
    case (acc)
      ACC_LOAD:  acc_bad = !(r || (x && mxr));
      ACC_STORE: acc_bad = !w;
      default:   acc_bad = !x;
    endcase
    bad = !v || (!is_ptr && (rsv_bad || priv_bad || mis_bad || acc_bad));

    pr = r || (x && mxr);
    px = x;
    pw = w && (acc == ACC_STORE || d);

    wb_data = pte;
    wb_data[B_A] = 1'b1;
    if (acc == ACC_STORE) wb_data[B_D] = 1'b1;
    wb_need = (wb_data != pte);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS = 2,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 22,
  parameter int PTE_W  = 32,
  parameter int PTE_LG = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xlat_on,
  input  logic [PPN_W-1:0]             root_ppn,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [LEVELS*IDX_W+OFF_W-1:0] req_vaddr,
  input  logic [1:0]                   req_acc,
  input  logic [1:0]                   req_priv,
  input  logic                         req_sum,
  input  logic                         req_mxr,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic                         mem_req_write,
  output logic [PPN_W+OFF_W-1:0]       mem_req_addr,
  output logic [PTE_W-1:0]             mem_req_wdata,
  input  logic                         mem_rsp_valid,
  input  logic [PTE_W-1:0]             mem_rsp_data,
  input  logic                         mem_rsp_err,
  output logic                         res_valid,
  input  logic                         res_ready,
  output logic [PPN_W+OFF_W-1:0]       res_paddr,
  output logic                         res_fault,
  output logic                         res_r,
  output logic                         res_w,
  output logic                         res_x
);
  localparam int VA_W    = LEVELS * IDX_W + OFF_W;
  localparam int PA_W    = PPN_W + OFF_W;
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  walk_st_e         st;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q, priv_q;
  logic             sum_q, mxr_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PPN_W-1:0] base_q;
  logic [PTE_W-1:0] wb_q;

  logic [PA_W-1:0]  pte_addr, leaf_paddr;
  logic [PPN_W-1:0] lvl_mask;
  logic             is_ptr, bad, pr, pw, px, wb_need;
  logic [PTE_W-1:0] wb_data;

  ptw_idx_gen #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W),
    .PTE_LG(PTE_LG), .LVL_W(LVL_W), .VA_W(VA_W), .PA_W(PA_W)
  ) u_idx (
    .base_ppn  (base_q),
    .vaddr     (va_q),
    .lvl       (lvl_q),
    .leaf_ppn  (mem_rsp_data[PTE_W-1:PPN_LSB]),
    .pte_addr  (pte_addr),
    .leaf_paddr(leaf_paddr),
    .lvl_mask  (lvl_mask)
  );

  ptw_leaf_eval #(.PPN_W(PPN_W), .PTE_W(PTE_W)) u_leaf (
    .pte     (mem_rsp_data),
    .mis_mask(lvl_mask),
    .acc     (acc_q),
    .priv    (priv_q),
    .sum     (sum_q),
    .mxr     (mxr_q),
    .is_ptr  (is_ptr),
    .bad     (bad),
    .pr      (pr),
    .pw      (pw),
    .px      (px),
    .wb_need (wb_need),
    .wb_data (wb_data)
  );

  assign req_ready     = (st == ST_IDLE);
  assign res_valid     = (st == ST_DONE);
  assign mem_req_valid = (st == ST_READ) || (st == ST_WBACK);
  assign mem_req_write = (st == ST_WBACK);
  assign mem_req_addr  = pte_addr;
  assign mem_req_wdata = wb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      va_q      <= '0;
      acc_q     <= '0;
      priv_q    <= '0;
      sum_q     <= 1'b0;
      mxr_q     <= 1'b0;
      lvl_q     <= '0;
      base_q    <= '0;
      wb_q      <= '0;
      res_paddr <= '0;
      res_fault <= 1'b0;
      res_r     <= 1'b0;
      res_w     <= 1'b0;
      res_x     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          acc_q  <= req_acc;
          priv_q <= req_priv;
          sum_q  <= req_sum;
          mxr_q  <= req_mxr;
          base_q <= root_ppn;
          lvl_q  <= TOP_LVL;
          if (req_priv == PRIV_M || !xlat_on) begin
            res_paddr <= PA_W'(req_vaddr);
            res_fault <= 1'b0;
            res_r     <= 1'b1;
            res_w     <= 1'b1;
            res_x     <= 1'b1;
            st        <= ST_DONE;
          end else begin
            st <= ST_READ;
          end
        end
        ST_READ: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_err && is_ptr && lvl_q != '0) begin
            base_q <= mem_rsp_data[PTE_W-1:PPN_LSB];
            lvl_q  <= lvl_q - LVL_W'(1);
            st     <= ST_READ;
          end else if (mem_rsp_err || is_ptr || bad) begin
            res_paddr <= '0;
            res_fault <= 1'b1;
            res_r     <= 1'b0;
            res_w     <= 1'b0;
            res_x     <= 1'b0;
            st        <= ST_DONE;
          end else begin
            res_paddr <= leaf_paddr;
            res_fault <= 1'b0;
            res_r     <= pr;
            res_w     <= pw;
            res_x     <= px;
            wb_q      <= wb_data;
            st        <= wb_need ? ST_WBACK : ST_DONE;
          end
        end
        ST_WBACK: if (mem_req_ready) st <= ST_DONE;
        ST_DONE:  if (res_ready) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R12: a waiting result must not move
  p_res_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr) &&
      $stable(res_fault) && $stable({res_r, res_w, res_x}));

  // R12: a waiting memory request must not move
  p_mreq_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid &&
      $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata));

  // R12: a fault carries no address and no permission
  p_fault_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_paddr == '0 && !res_r && !res_w && !res_x);

  // R13: an idle walker drives no request and no result
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !res_valid);

  // R8: every writeback carries the accessed flag
  p_wb_accessed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[B_A]);

  // R10: a successful store always reports write permission
  p_store_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault && acc_q == ACC_STORE |-> res_w);
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlat_on = 1'b0;
  logic [21:0] root_ppn = 22'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0, req_priv = '0;
  logic        req_sum = 1'b0, req_mxr = 1'b0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [33:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        res_valid, res_fault, res_r, res_w, res_x;
  logic        res_ready = 1'b0;
  logic [33:0] res_paddr;

  int total = 0;
  int bad = 0;
  logic [31:0] mem [0:4095];
  int rd_cnt, wr_cnt;
  logic [33:0] first_rd;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk, .rst_n, .xlat_on, .root_ppn, .req_valid, .req_ready, .req_vaddr,
    .req_acc, .req_priv, .req_sum, .req_mxr, .mem_req_valid, .mem_req_ready,
    .mem_req_write, .mem_req_addr, .mem_req_wdata, .mem_rsp_valid,
    .mem_rsp_data, .mem_rsp_err, .res_valid, .res_ready, .res_paddr,
    .res_fault, .res_r, .res_w, .res_x
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory model: random ready, reads answered after 1..3 cycles
  initial begin : mem_model
    logic        pend = 1'b0;
    int          dly = 0;
    logic [33:0] a = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          pend = 1'b0;
          mem_rsp_valid = 1'b1;
          mem_rsp_err   = (a >= 34'd16384);
          mem_rsp_data  = mem_rsp_err ? $urandom : mem[a[13:2]];
        end else dly--;
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          wr_cnt++;
          if (mem_req_addr < 34'd16384) mem[mem_req_addr[13:2]] = mem_req_wdata;
        end else begin
          if (rd_cnt == 0) first_rd = mem_req_addr;
          rd_cnt++;
          pend = 1'b1;
          a    = mem_req_addr;
          dly  = $urandom % 3;
        end
      end
    end
  end

  // reference built from the requirements
  task automatic model(input logic [31:0] va, input logic [1:0] acc,
      input logic [1:0] priv, input logic sum, input logic mxr, input logic on,
      output logic f, output logic [33:0] pa, output logic [2:0] rwx,
      output logic wb, output logic [33:0] wba, output logic [31:0] wbd,
      output string tag, output logic [33:0] a1);
    logic [21:0] base = root_ppn;
    f = 1'b1; pa = '0; rwx = '0; wb = 1'b0; wba = '0; wbd = '0; a1 = '0;
    if (priv == 2'd3 || !on) begin
      f = 1'b0; pa = {2'b00, va}; rwx = 3'b111; tag = "R1"; return;
    end
    for (int l = 1; l >= 0; l--) begin
      logic [33:0] a;
      logic [31:0] p;
      logic [21:0] ppn;
      logic v, r, w, x, u, d;
      a = {base, 12'h000} + 34'((l == 1 ? va[31:22] : va[21:12]) * 4);
      if (l == 1) a1 = a;
      if (a >= 34'd16384) begin tag = "R11"; return; end
      p = mem[a[13:2]];
      v = p[0]; r = p[1]; w = p[2]; x = p[3]; u = p[4]; d = p[7];
      ppn = p[31:10];
      if (!v) begin tag = "R3"; return; end
      if (!r && !w && !x) begin
        if (l == 0) begin tag = "R3"; return; end
        base = ppn;
        continue;
      end
      if (w && !r) begin tag = "R4"; return; end
      if ((u && priv != 2'd0 && (!sum || acc == 2'd0)) ||
          (!u && priv != 2'd1)) begin tag = "R5"; return; end
      if (l == 1 && ppn[9:0] != 0) begin tag = "R6"; return; end
      if ((acc == 2'd1 && !(r || (x && mxr))) || (acc == 2'd2 && !w) ||
          (acc == 2'd0 && !x)) begin tag = "R7"; return; end
      f   = 1'b0;
      wbd = p | 32'h40 | (acc == 2'd2 ? 32'h80 : 32'h0);
      wb  = (wbd != p);
      wba = a;
      pa  = (l == 1) ? {ppn[21:10], va[21:0]} : {ppn, va[11:0]};
      rwx = {r || (x && mxr), w && (acc == 2'd2 || d), x};
      tag = "R9";
      return;
    end
  endtask

  task automatic run_case(input logic [31:0] va, input logic [1:0] acc,
      input logic [1:0] priv, input logic sum, input logic mxr, input logic on);
    logic ef, wb, seen = 1'b0, got = 1'b0;
    logic [33:0] epa, wba, a1, hpa;
    logic [2:0] erwx, hrwx;
    logic [31:0] wbd;
    logic hf;
    string tag;
    model(va, acc, priv, sum, mxr, on, ef, epa, erwx, wb, wba, wbd, tag, a1);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; first_rd = '0;
    req_vaddr = va; req_acc = acc; req_priv = priv;
    req_sum = sum; req_mxr = mxr; xlat_on = on; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 300 && !got; i++) begin
      if (res_valid) begin
        if (seen) begin
          chk("R12", "held paddr", res_paddr, hpa);
          chk("R12", "held flags", {res_fault, res_r, res_w, res_x}, {hf, hrwx});
        end
        seen = 1'b1; hpa = res_paddr; hf = res_fault;
        hrwx = {res_r, res_w, res_x};
        res_ready = ($urandom % 3) != 0;
        if (res_ready) got = 1'b1;
      end
      @(negedge clk);
    end
    res_ready = 1'b0;
    if (!got) begin
      total++; bad++;
      $display("FAIL R12 result missing actual=0 expected=1");
      return;
    end
    chk(tag, "fault", hf, ef);
    chk(tag == "R9" ? "R9" : tag, "paddr", hpa, epa);
    chk(ef ? tag : "R10", "perms", hrwx, erwx);
    chk("R8", "write count", wr_cnt, wb ? 1 : 0);
    if (wb) chk("R8", "written entry", mem[wba[13:2]], wbd);
    if (tag == "R1") chk("R1", "reads in bypass", rd_cnt, 0);
    else chk("R2", "first entry address", first_rd, a1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h1357));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R13", "req_ready", req_ready, 1);
    chk("R13", "res_valid", res_valid, 0);
    chk("R13", "mem_req_valid", mem_req_valid, 0);
    rst_n = 1'b1;

    // R1: machine mode and bare mode
    run_case(32'hDEAD_BEEF, 2'd2, 2'd3, 1'b0, 1'b0, 1'b1);
    run_case(32'h1234_5678, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0);
    // R11: pointer into the error region
    mem[1024 + 5] = {22'h100, 10'h001};
    run_case({10'd5, 10'd7, 12'h123}, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1);
    // R3: pointer found at the last level
    mem[1024 + 6] = {22'd2, 10'h001};
    mem[2048 + 9] = {22'd2, 10'h001};
    run_case({10'd6, 10'd9, 12'h010}, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1);
    // R8 R9: superpage store sets dirty and splices low bits
    mem[1024 + 7] = {22'h000C00, 10'h047};
    run_case({10'd7, 10'h2AB, 12'hFED}, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1);
    // R8: load of an entry already accessed and dirty writes nothing
    mem[1024 + 8] = {22'd3, 10'h001};
    mem[3072 + 4] = {22'h0ABCDE, 10'h0C3};
    run_case({10'd8, 10'd4, 12'h444}, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1);
    // R6: misaligned superpage
    mem[1024 + 9] = {22'h000C01, 10'h0CF};
    run_case({10'd9, 10'd1, 12'h0}, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1);

    for (int t = 0; t < 500; t++) begin
      logic [9:0] v1, v0;
      logic [7:0] fl;
      int k;
      logic [1:0] pv;
      v1 = 10'($urandom); v0 = 10'($urandom);
      k  = $urandom % 8;
      fl = 8'($urandom);
      case (k)
        0: mem[1024 + v1] = {22'($urandom), fl & 8'hFE, 2'b00};
        1: mem[1024 + v1] = {22'h100 + 22'($urandom % 64), 10'h001};
        2: mem[1024 + v1] = {12'($urandom), 10'h000, 2'b00, fl | 8'h01};
        3: mem[1024 + v1] = {22'($urandom), 2'b00, fl | 8'h01};
        default: mem[1024 + v1] = {20'd0, 2'(2 + ($urandom % 2)), 2'b00,
                                   (fl & 8'hF0) | 8'h01};
      endcase
      fl = 8'($urandom);
      if ($urandom % 8 != 0) fl = fl | 8'h01;
      mem[2048 + v0] = {22'($urandom), 2'b00, fl};
      mem[3072 + v0] = {22'($urandom), 2'b00, fl ^ 8'h1E};
      pv = ($urandom % 5 == 0) ? 2'd3 : 2'($urandom % 2);
      run_case({v1, v0, 12'($urandom)}, 2'($urandom % 3), pv,
               1'($urandom), 1'($urandom), ($urandom % 8) != 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule